// File: doc/BRIEF.md
# Dual-Host Shared Memory Multiplexer

This block places one 18-bit word-organised memory between two hosts that run from unrelated clocks. Port A is a native host that reads and writes full 18-bit words by word address. Port B is a 16-bit, byte-addressed bus that may be driven by a processor or by DMA masters. Two extra data lines on port B carry memory bits 17:16, so a DMA master can move a full 18-bit word.

Each port raises a level request. The request passes through a synchroniser and then meets a fixed-priority arbiter that favours port A. The block then runs one memory operation on a simple synchronous single-port memory whose read data arrives one cycle after the read is issued. Port B operations that the word-only memory cannot perform directly are built from native reads and writes. A byte write becomes a read, a merge and a write. A locked read keeps the memory reserved for port B until that port's next write. Request fields must stay stable while a request is high. A host drops its request after the acknowledge and keeps it low for at least three cycles before the next request.

Top module: `shmem_mux`

## Requirements
- R1: When both ports have a pending request while the memory is idle and not locked, port A is served first. Port B is served only after port A's operation completes.
- R2: Each request passes a two-stage synchroniser. Acknowledge latency counts rising edges, with the first edge that samples the request as edge 1. An uncontended read is acknowledged after edge 5, a native or 16-bit write after edge 4, and a port B byte write after edge 6.
- R3: A port B byte address selects memory word `b_addr >> 1`. A port B read (`b_op` = 0) returns bits 15:0 of that word on `b_rdata`, whatever the value of address bit 0.
- R4: Port B reads return memory bits 17:16 on `b_xrdata`. A port B word write (`b_op` = 2) with `b_xvalid` = 1 stores `b_xdata` into bits 17:16 and `b_wdata` into bits 15:0.
- R5: A port B word write with `b_xvalid` = 0 stores zero into bits 17:16.
- R6: A port B byte write (`b_op` = 3) with `b_addr[0]` = 0 replaces bits 7:0 with `b_wdata[7:0]`. With `b_addr[0]` = 1 it replaces bits 15:8 with `b_wdata[15:8]`. All other bits of the word, including 17:16, are kept.
- R7: After a port B locked read (`b_op` = 1) is acknowledged, no port A request is served until port B completes a word write or byte write. Port B reads in that window do not release the lock.
- R8: Each acknowledge is high for exactly one cycle. The two acknowledges are never high together. A request that stays high after its acknowledge is not served again until it has been seen low.
- R9: A grant, and the address it was given, are held unchanged from the start of a memory operation until its acknowledge.
- R10: While reset is high, both acknowledges and the memory enable are low.
- R11: A port A write (`a_we` = 1) stores all 18 bits of `a_wdata`. A port A read returns all 18 bits of the addressed word on `a_rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock of the memory side |
| rst | input | 1 | Synchronous active-high reset |
| a_req | input | 1 | Port A request level |
| a_we | input | 1 | Port A: 1 = write, 0 = read |
| a_addr | input | AW | Port A word address |
| a_wdata | input | 18 | Port A write word |
| a_ack | output | 1 | Port A one-cycle acknowledge |
| a_rdata | output | 18 | Port A read word, valid with a_ack |
| b_req | input | 1 | Port B request level |
| b_op | input | 2 | Port B cycle: 0 read, 1 locked read, 2 word write, 3 byte write |
| b_addr | input | AW+1 | Port B byte address |
| b_wdata | input | 16 | Port B write data |
| b_xdata | input | 2 | Port B extra write bits for memory bits 17:16 |
| b_xvalid | input | 1 | Port B extra bits are valid on a word write |
| b_ack | output | 1 | Port B one-cycle acknowledge |
| b_rdata | output | 16 | Port B read data, memory bits 15:0 |
| b_xrdata | output | 2 | Port B read data, memory bits 17:16 |
| m_en | output | 1 | Memory access enable |
| m_we | output | 1 | Memory write enable |
| m_addr | output | AW | Memory word address |
| m_wdata | output | 18 | Memory write word |
| m_rdata | input | 18 | Memory read word, valid one cycle after a read |

## Verification
The bench raises both requests on the same edge, with reads and with colliding writes to one word. A design that weighed the ports the other way would leave port A's data in the word instead of port B's. Byte writes go to both halves of a word whose bits 17:16 are set. A merge that picked the wrong lane, or that dropped the extra bits, would leave a word that no longer matches the reference memory. A port A request is placed inside a locked window. A lock that released early would let port A see the word before the closing write. A request is also held high well past its acknowledge, and a missing served-once flag would show up there as a second acknowledge.

// File: rtl/shmem_pkg.sv
package shmem_pkg;

    localparam int WORD_W = 18;
    localparam int HALF_W = 16;
    localparam int XTRA_W = WORD_W - HALF_W;

    // Port B cycle codes
    typedef enum logic [1:0] {
        BOP_READ       = 2'd0,
        BOP_READ_LOCK  = 2'd1,
        BOP_WRITE_WORD = 2'd2,
        BOP_WRITE_BYTE = 2'd3
    } bop_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FETCH,
        ST_CAPTURE,
        ST_STORE
    } st_e;

    // One granted memory operation
    typedef struct packed {
        logic              from_b;
        logic              write;
        logic              merge;
        logic              take_lock;
        logic              drop_lock;
        logic              upper;
        logic [WORD_W-1:0] wdata;
    } job_t;

    // Put one byte into the chosen lane of a word; all other bits are kept
    function automatic logic [WORD_W-1:0] merge_byte(
        input logic [WORD_W-1:0] old_word,
        input logic [7:0]        new_byte,
        input logic              upper
    );
        logic [WORD_W-1:0] r;
        r = old_word;
        if (upper) r[15:8] = new_byte;
        else       r[7:0]  = new_byte;
        return r;
    endfunction

    // Build a native word from port B data and the extra bits
    function automatic logic [WORD_W-1:0] widen_b(
        input logic [HALF_W-1:0] d,
        input logic [XTRA_W-1:0] x,
        input logic              xv
    );
        return {(xv ? x : {XTRA_W{1'b0}}), d};
    endfunction

endpackage

// File: rtl/shmem_sync.sv
module shmem_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/shmem_arb.sv
module shmem_arb (
    input  logic idle,
    input  logic a_pend,
    input  logic b_pend,
    input  logic locked,
    output logic gnt_a,
    output logic gnt_b
);
    // Fixed priority to port A, unless port B holds the lock
    always_comb begin
        gnt_a = idle & a_pend & ~locked;
        gnt_b = idle & b_pend & ~gnt_a;
    end
endmodule

// File: rtl/shmem_mux.sv
module shmem_mux
    import shmem_pkg::*;
#(
    parameter int AW          = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              a_req,
    input  logic              a_we,
    input  logic [AW-1:0]     a_addr,
    input  logic [WORD_W-1:0] a_wdata,
    output logic              a_ack,
    output logic [WORD_W-1:0] a_rdata,
    input  logic              b_req,
    input  logic [1:0]        b_op,
    input  logic [AW:0]       b_addr,
    input  logic [HALF_W-1:0] b_wdata,
    input  logic [XTRA_W-1:0] b_xdata,
    input  logic              b_xvalid,
    output logic              b_ack,
    output logic [HALF_W-1:0] b_rdata,
    output logic [XTRA_W-1:0] b_xrdata,
    output logic              m_en,
    output logic              m_we,
    output logic [AW-1:0]     m_addr,
    output logic [WORD_W-1:0] m_wdata,
    input  logic [WORD_W-1:0] m_rdata
);
    logic          a_req_s, b_req_s;
    logic          a_done, b_done, locked;
    logic          a_pend, b_pend, gnt_a, gnt_b, idle;
    st_e           state;
    job_t          job, nj;
    logic [AW-1:0] addr_q, na;
    bop_e          b_kind;

    shmem_sync #(.STAGES(SYNC_STAGES)) u_sync_a (.clk(clk), .rst(rst), .d(a_req), .q(a_req_s));
    shmem_sync #(.STAGES(SYNC_STAGES)) u_sync_b (.clk(clk), .rst(rst), .d(b_req), .q(b_req_s));

    assign a_pend = a_req_s & ~a_done;
    assign b_pend = b_req_s & ~b_done;
    assign idle   = (state == ST_IDLE);
    assign b_kind = bop_e'(b_op);

    shmem_arb u_arb (
        .idle  (idle),
        .a_pend(a_pend),
        .b_pend(b_pend),
        .locked(locked),
        .gnt_a (gnt_a),
        .gnt_b (gnt_b)
    );

    // Translate the winning request into a native job
    always_comb begin
        nj = '0;
        na = a_addr;
        if (gnt_a) begin
            nj.write = a_we;
            nj.wdata = a_wdata;
        end else begin
            na           = b_addr[AW:1];
            nj.from_b    = 1'b1;
            nj.upper     = b_addr[0];
            nj.write     = (b_kind == BOP_WRITE_WORD);
            nj.merge     = (b_kind == BOP_WRITE_BYTE);
            nj.take_lock = (b_kind == BOP_READ_LOCK);
            nj.drop_lock = (b_kind == BOP_WRITE_WORD) || (b_kind == BOP_WRITE_BYTE);
            nj.wdata     = widen_b(b_wdata, b_xdata, b_xvalid);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            job      <= '0;
            addr_q   <= '0;
            a_ack    <= 1'b0;
            b_ack    <= 1'b0;
            a_rdata  <= '0;
            b_rdata  <= '0;
            b_xrdata <= '0;
            a_done   <= 1'b0;
            b_done   <= 1'b0;
            locked   <= 1'b0;
        end else begin
            a_ack <= 1'b0;
            b_ack <= 1'b0;
            if (!a_req_s) a_done <= 1'b0;
            if (!b_req_s) b_done <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (gnt_a || gnt_b) begin
                        job    <= nj;
                        addr_q <= na;
                        state  <= nj.write ? ST_STORE : ST_FETCH;
                    end
                end
                ST_FETCH: state <= ST_CAPTURE;
                ST_CAPTURE: begin
                    if (job.merge) begin
                        job.wdata <= merge_byte(m_rdata,
                                                job.upper ? job.wdata[15:8] : job.wdata[7:0],
                                                job.upper);
                        state     <= ST_STORE;
                    end else begin
                        if (job.from_b) begin
                            b_ack    <= 1'b1;
                            b_done   <= 1'b1;
                            b_rdata  <= m_rdata[HALF_W-1:0];
                            b_xrdata <= m_rdata[WORD_W-1:HALF_W];
                            if (job.take_lock) locked <= 1'b1;
                        end else begin
                            a_ack   <= 1'b1;
                            a_done  <= 1'b1;
                            a_rdata <= m_rdata;
                        end
                        state <= ST_IDLE;
                    end
                end
                ST_STORE: begin
                    if (job.from_b) begin
                        b_ack  <= 1'b1;
                        b_done <= 1'b1;
                        if (job.drop_lock) locked <= 1'b0;
                    end else begin
                        a_ack  <= 1'b1;
                        a_done <= 1'b1;
                    end
                    state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign m_en    = (state == ST_FETCH) || (state == ST_STORE);
    assign m_we    = (state == ST_STORE);
    assign m_addr  = addr_q;
    assign m_wdata = job.wdata;

    // Port A wins a tie when the memory is free and unlocked
    assert_a_first_R1: assert property (@(posedge clk) disable iff (rst)
        (idle && a_pend && b_pend && !locked) |=> (!idle && !job.from_b));

    // Acknowledges are single-cycle pulses and never coincide
    assert_a_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        a_ack |=> !a_ack);
    assert_b_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        b_ack |=> !b_ack);
    assert_acks_apart_R8: assert property (@(posedge clk) disable iff (rst)
        !(a_ack && b_ack));

    // Under lock, an idle memory hands out nothing to port A
    assert_lock_blocks_a_R7: assert property (@(posedge clk) disable iff (rst)
        (locked && idle) |=> (idle || job.from_b));

    // Owner and address stay fixed through a read phase
    assert_grant_held_R9: assert property (@(posedge clk) disable iff (rst)
        (state == ST_FETCH || state == ST_CAPTURE) |=> ($stable(job.from_b) && $stable(addr_q)));

    // The write-back of a byte merge keeps the untouched bits of the word just read
    assert_merge_keeps_R6: assert property (@(posedge clk) disable iff (rst)
        (state == ST_STORE && job.merge) |->
            (m_wdata[17:16] == $past(m_rdata[17:16])) &&
            (job.upper ? (m_wdata[7:0] == $past(m_rdata[7:0]))
                       : (m_wdata[15:8] == $past(m_rdata[15:8]))));

endmodule

// File: tb/sim_shmem_mux.sv
`timescale 1ns/1ps
module sim_shmem_mux;
    import shmem_pkg::*;

    localparam int AW    = 8;
    localparam int DEPTH = 1 << AW;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              a_req = 1'b0, a_we = 1'b0;
    logic [AW-1:0]     a_addr = '0;
    logic [17:0]       a_wdata = '0;
    logic              a_ack;
    logic [17:0]       a_rdata;
    logic              b_req = 1'b0;
    logic [1:0]        b_op = 2'd0;
    logic [AW:0]       b_addr = '0;
    logic [15:0]       b_wdata = '0;
    logic [1:0]        b_xdata = '0;
    logic              b_xvalid = 1'b0;
    logic              b_ack;
    logic [15:0]       b_rdata;
    logic [1:0]        b_xrdata;
    logic              m_en, m_we;
    logic [AW-1:0]     m_addr;
    logic [17:0]       m_wdata;
    logic [17:0]       m_rdata;

    always #2 clk = ~clk;

    shmem_mux #(.AW(AW)) u0 (
        .clk(clk), .rst(rst),
        .a_req(a_req), .a_we(a_we), .a_addr(a_addr), .a_wdata(a_wdata),
        .a_ack(a_ack), .a_rdata(a_rdata),
        .b_req(b_req), .b_op(b_op), .b_addr(b_addr), .b_wdata(b_wdata),
        .b_xdata(b_xdata), .b_xvalid(b_xvalid),
        .b_ack(b_ack), .b_rdata(b_rdata), .b_xrdata(b_xrdata),
        .m_en(m_en), .m_we(m_we), .m_addr(m_addr), .m_wdata(m_wdata),
        .m_rdata(m_rdata)
    );

    // Physical memory seen by the block, and the reference memory
    logic [17:0] phys    [DEPTH];
    logic [17:0] exp_mem [DEPTH];

    always @(posedge clk) begin
        if (m_en) begin
            if (m_we) phys[m_addr] <= m_wdata;
            else      m_rdata      <= phys[m_addr];
        end
    end

    int checks = 0, errors = 0, cyc = 0;
    bit done_flag = 0;

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", tag, act, expv);
        end
    endtask

    // Reference tracking of what each port asked for
    bit            a_wait = 0, b_wait = 0, exp_locked = 0, prev_a = 0, prev_b = 0;
    bit            a_cur_we;
    logic [AW-1:0] a_cur_addr;
    logic [17:0]   a_cur_wd;
    bop_e          b_cur_op;
    logic [AW:0]   b_cur_addr;
    logic [15:0]   b_cur_wd;
    logic [1:0]    b_cur_x;
    bit            b_cur_xv;
    int            a_ack_cyc = 0, b_ack_cyc = 0;

    always @(posedge clk) cyc++;

    always @(negedge clk) begin
        if (!rst) begin
            check(!(a_ack && b_ack), "R8 acks together", {a_ack, b_ack}, 0);
            if (a_ack) begin
                check(a_wait, "R8 port A ack with nothing pending", a_ack, 0);
                check(!prev_a, "R8 port A ack longer than one cycle", prev_a, 0);
                check(!exp_locked, "R7 port A served under lock", exp_locked, 0);
                if (a_wait) begin
                    if (!a_cur_we) begin
                        check(a_rdata == exp_mem[a_cur_addr], "R11 port A read", a_rdata, exp_mem[a_cur_addr]);
                    end else begin
                        exp_mem[a_cur_addr] = a_cur_wd;
                        check(phys[a_cur_addr] == exp_mem[a_cur_addr], "R11 port A write", phys[a_cur_addr], exp_mem[a_cur_addr]);
                    end
                end
                a_wait    = 0;
                a_ack_cyc = cyc;
            end
            if (b_ack) begin
                logic [AW-1:0] w;
                logic [17:0]   e;
                w = b_cur_addr[AW:1];
                check(b_wait, "R8 port B ack with nothing pending", b_ack, 0);
                check(!prev_b, "R8 port B ack longer than one cycle", prev_b, 0);
                if (b_wait) begin
                    case (b_cur_op)
                        BOP_READ, BOP_READ_LOCK: begin
                            e = exp_mem[w];
                            check(b_rdata == e[15:0], "R3 port B read data", b_rdata, e[15:0]);
                            check(b_xrdata == e[17:16], "R4 port B extra read bits", b_xrdata, e[17:16]);
                            if (b_cur_op == BOP_READ_LOCK) exp_locked = 1;
                        end
                        BOP_WRITE_WORD: begin
                            exp_mem[w] = {(b_cur_xv ? b_cur_x : 2'b00), b_cur_wd};
                            check(phys[w] == exp_mem[w], b_cur_xv ? "R4 word write with extra bits" : "R5 word write clears extra bits",
                                  phys[w], exp_mem[w]);
                            exp_locked = 0;
                        end
                        default: begin
                            e = exp_mem[w];
                            if (b_cur_addr[0]) e[15:8] = b_cur_wd[15:8];
                            else               e[7:0]  = b_cur_wd[7:0];
                            exp_mem[w] = e;
                            check(phys[w] == e, "R6 byte write merge", phys[w], e);
                            exp_locked = 0;
                        end
                    endcase
                end
                b_wait    = 0;
                b_ack_cyc = cyc;
            end
        end
        prev_a = a_ack;
        prev_b = b_ack;
    end

    task automatic do_a(input bit we, input logic [AW-1:0] ad, input logic [17:0] wd,
                        input int exp_lat, input int hold);
        int n;
        a_we = we; a_addr = ad; a_wdata = wd;
        a_cur_we = we; a_cur_addr = ad; a_cur_wd = wd;
        a_wait = 1;
        a_req = 1;
        n = 0;
        do begin @(negedge clk); n++; end while (!a_ack);
        if (exp_lat > 0) check(n == exp_lat, "R2 port A latency", n, exp_lat);
        repeat (hold) @(negedge clk);
        #1 a_req = 0;
        repeat (4) @(negedge clk);
        #1;
    endtask

    task automatic do_b(input bop_e op, input logic [AW:0] ad, input logic [15:0] wd,
                        input logic [1:0] x, input bit xv, input int exp_lat);
        int n;
        b_op = op; b_addr = ad; b_wdata = wd; b_xdata = x; b_xvalid = xv;
        b_cur_op = op; b_cur_addr = ad; b_cur_wd = wd; b_cur_x = x; b_cur_xv = xv;
        b_wait = 1;
        b_req = 1;
        n = 0;
        do begin @(negedge clk); n++; end while (!b_ack);
        if (exp_lat > 0) check(n == exp_lat, "R2 port B latency", n, exp_lat);
        #1 b_req = 0;
        repeat (4) @(negedge clk);
        #1;
    endtask

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) begin
            phys[i]    = {2'b11, 16'(i * 257) ^ 16'h5A3C};
            exp_mem[i] = phys[i];
        end
        repeat (5) @(negedge clk);
        // R10: quiet outputs during reset
        check(!a_ack && !b_ack && !m_en, "R10 reset state", {a_ack, b_ack, m_en}, 0);
        #1 rst = 0;
        repeat (3) @(negedge clk);
        #1;

        // R11 / R2: native write and read
        do_a(1, 8'd5, 18'h2A5C3, 4, 0);
        do_a(0, 8'd5, 18'h0, 5, 0);

        // R3 / R4: both byte addresses of a word give the same word
        do_b(BOP_READ, 9'd10, 16'h0, 2'b00, 0, 5);
        do_b(BOP_READ, 9'd11, 16'h0, 2'b00, 0, 5);

        // R4: word write carrying extra bits
        do_b(BOP_WRITE_WORD, 9'd14, 16'hBEEF, 2'b01, 1, 4);
        do_a(0, 8'd7, 18'h0, 5, 0);
        check(a_rdata == 18'h1BEEF, "R4 extra bits reach memory", a_rdata, 18'h1BEEF);

        // R5: word write without extra bits clears 17:16
        do_b(BOP_WRITE_WORD, 9'd16, 16'hCAFE, 2'b11, 0, 4);
        do_a(0, 8'd8, 18'h0, 5, 0);
        check(a_rdata == 18'h0CAFE, "R5 extra bits cleared", a_rdata, 18'h0CAFE);

        // R6: byte writes to both lanes of a word with 17:16 set
        do_b(BOP_WRITE_BYTE, 9'd18, 16'h1234, 2'b00, 0, 6);
        do_b(BOP_WRITE_BYTE, 9'd19, 16'h5678, 2'b00, 0, 6);
        do_a(0, 8'd9, 18'h0, 5, 0);
        check(a_rdata == 18'h35634, "R6 merged word", a_rdata, 18'h35634);

        // R8: request held after its acknowledge is not served twice
        do_a(0, 8'd12, 18'h0, 5, 12);

        // R1: simultaneous reads
        fork
            do_a(0, 8'd3, 18'h0, 0, 0);
            do_b(BOP_READ, 9'd6, 16'h0, 2'b00, 0, 0);
        join
        check(a_ack_cyc < b_ack_cyc, "R1 port A first on reads", a_ack_cyc, b_ack_cyc);

        // R1: simultaneous writes to one word; port B's data must end up stored
        fork
            do_a(1, 8'd20, 18'h11111, 0, 0);
            do_b(BOP_WRITE_WORD, 9'd40, 16'h2222, 2'b10, 1, 0);
        join
        check(phys[20] == 18'h22222, "R1 later writer is port B", phys[20], 18'h22222);

        // R7: locked read, port A waits for the closing byte write
        do_b(BOP_READ_LOCK, 9'd60, 16'h0, 2'b00, 0, 5);
        fork
            do_a(0, 8'd30, 18'h0, 0, 0);
            begin
                repeat (8) @(negedge clk);
                #1;
                do_b(BOP_READ, 9'd61, 16'h0, 2'b00, 0, 5);
                do_b(BOP_WRITE_BYTE, 9'd60, 16'h00AA, 2'b00, 0, 6);
            end
        join
        check(a_ack_cyc > b_ack_cyc, "R7 port A after closing write", a_ack_cyc, b_ack_cyc);
        // R7: lock released, port A runs at full speed again
        do_a(0, 8'd30, 18'h0, 5, 0);

        // R7: locked read closed by a word write
        do_b(BOP_READ_LOCK, 9'd70, 16'h0, 2'b00, 0, 5);
        fork
            do_a(1, 8'd35, 18'h00777, 0, 0);
            begin
                repeat (6) @(negedge clk);
                #1;
                do_b(BOP_WRITE_WORD, 9'd70, 16'h4321, 2'b11, 1, 4);
            end
        join
        check(a_ack_cyc > b_ack_cyc, "R7 port A held until word write", a_ack_cyc, b_ack_cyc);

        repeat (4) @(negedge clk);
        finish_run();
    end
endmodule